// File: doc/BRIEF.md
# Stacked Register Frame Mapper

This block turns a logical integer register number (0 to 127) into an index in a physical register file. It also holds that file, so that it can run its own save and restore traffic. Registers 0 to 31 are global and always map to themselves. Registers 32 to 127 are windowed: each procedure sees its own frame, whose size is set when the procedure is called. Logical register 32 is always the first register of the current frame. The windowed part of the physical file is a circular buffer of `PHYS` entries. Successive frames sit end to end in one growing stack. A register's absolute stack position is its frame start plus its offset in the frame, and that position, taken modulo `PHYS`, picks its physical slot.

A call pushes the caller's frame start and size and opens a fresh frame just above the caller's frame. A return pops them. When the live frames no longer fit in `PHYS` slots, the block raises `stall_o` and writes the oldest registers to memory without any help from software, one per accepted request. When a return lands on a frame whose bottom has been written out, the block stalls again and reads those registers back. A flush request writes every resident register out, so that system software can save the whole stack on a context switch. The memory address of every transfer is the register's absolute stack position. `bs_top_o` marks the boundary between registers held in memory and registers held in the buffer.

Top module: `stack_frame_mapper`

## Requirements
- R1: Logical registers 0 to 31 report physical index equal to their number, and keep their contents across calls and returns.
- R2: A logical register n from 32 up, inside the current frame, reports physical index 32 + ((S + n - 32) mod PHYS). S is the frame's absolute start, which equals the caller's start plus the caller's size.
- R3: A call opens a frame of size min(alloc_i, PHYS). Reading a windowed register at or beyond that size returns zero, and writing one changes no register.
- R4: A return restores the caller's frame start and size, and the caller's registers read back the values they held before the call.
- R5: A call while DEPTH frames are already saved is ignored, and a return with no saved frame is ignored.
- R6: When the resident count (frame top minus bs_top_o) exceeds PHYS, stall_o is high in the cycle after the call. The block then issues write requests for positions bs_top_o, bs_top_o+1, and so on in ascending order, and bs_top_o rises by one per accepted request until the count is at most PHYS.
- R7: After a return to a frame whose start lies below bs_top_o, stall_o is high in the next cycle. The block reads address bs_top_o-1 and downward, one outstanding read at a time, and writes each response into its slot. It decrements bs_top_o per response until bs_top_o equals the frame start, and the caller's values then read back intact.
- R8: The memory word at address a always holds the register at absolute stack position a.
- R9: A flush writes positions bs_top_o up to the frame top minus one, in ascending order, while stall_o is high. It leaves bs_top_o and every register value unchanged.
- R10: A memory request held without ready keeps its valid, address, write flag and write data unchanged.
- R11: While stall_o is high, register writes and call, return and flush requests are ignored, and no memory request is made unless stall_o is high.
- R12: After reset there is no frame, bs_top_o is zero, stall_o is low and no memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Open a new frame |
| ret_i | input | 1 | Return to the caller's frame |
| alloc_i | input | 7 | Requested size of the new frame |
| flush_i | input | 1 | Write all resident windowed registers to memory |
| rd_idx_i | input | 7 | Logical register to read |
| rd_phys_o | output | 7 | Physical index of rd_idx_i |
| rd_data_o | output | DW | Value of rd_idx_i |
| wr_en_i | input | 1 | Register write enable |
| wr_idx_i | input | 7 | Logical register to write |
| wr_data_i | input | DW | Write value |
| stall_o | output | 1 | Register access and frame requests are held off |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_we_o | output | 1 | 1 for a write (spill or flush), 0 for a read (fill) |
| mem_req_addr_o | output | AW | Word address, the absolute stack position |
| mem_req_wdata_o | output | DW | Data written to memory |
| mem_rsp_valid_i | input | 1 | Read data returned |
| mem_rsp_data_i | input | DW | Read data |
| bs_top_o | output | AW | Count of stack positions held in memory |

## Verification
The mapping is tried with nested frames that fit the buffer, which separates correct frame-start arithmetic from a fixed offset. A frame that fills the whole buffer shows whether clamping and the frame-end boundary are right. A second frame that overflows the buffer by six slots, followed by a return, checks the order and count of the spill and fill traffic. Because the callee overwrites the very slots it took over, a fill that restores the wrong data shows up. Memory readiness is made to stall at random during that sequence, which separates a held request from a dropped one. A flush over a partly spilled stack checks that only resident positions are written.

// File: rtl/stack_frame_mapper.sv
module stack_frame_mapper #(
  parameter int PHYS  = 64,
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic [6:0]    alloc_i,
  input  logic          flush_i,
  input  logic [6:0]    rd_idx_i,
  output logic [6:0]    rd_phys_o,
  output logic [DW-1:0] rd_data_o,
  input  logic          wr_en_i,
  input  logic [6:0]    wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          stall_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_req_we_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [DW-1:0] mem_req_wdata_o,
  input  logic          mem_rsp_valid_i,
  input  logic [DW-1:0] mem_rsp_data_i,
  output logic [AW-1:0] bs_top_o
);

  localparam int PB  = $clog2(PHYS);
  localparam int SW  = PB + 1;
  localparam int PW  = $clog2((DEPTH + 1) * PHYS + 1);
  localparam int DPW = $clog2(DEPTH + 1);
  localparam int IW  = $clog2(DEPTH);

  logic [DW-1:0] gr [32];
  logic [DW-1:0] sr [PHYS];

  logic [PW-1:0]  fstart, spos, fcnt, top, mpos;
  logic [SW-1:0]  fsize, asize;
  logic [PW-1:0]  stk_start [DEPTH];
  logic [SW-1:0]  stk_size  [DEPTH];
  logic [DPW-1:0] sp;
  logic [IW-1:0]  push_i, pop_i;
  logic           flushing, fill_wait;
  logic           need_spill, need_fill;

  logic [6:0]    rd_off, wr_off;
  logic          rd_in, wr_in;
  logic [PB-1:0] rd_slot, wr_slot, m_slot;

  assign top        = fstart + PW'(fsize);
  assign need_spill = (top - spos) > PW'(PHYS);
  assign need_fill  = spos > fstart;
  assign stall_o    = need_spill | need_fill | flushing;

  assign asize  = (alloc_i > 7'(PHYS)) ? SW'(PHYS) : alloc_i[SW-1:0];
  assign push_i = IW'(sp);
  assign pop_i  = IW'(sp - DPW'(1));

  assign rd_off  = rd_idx_i - 7'd32;
  assign rd_in   = (rd_idx_i >= 7'd32) && (rd_off < 7'(fsize));
  assign rd_slot = PB'(fstart + PW'(rd_off));
  assign wr_off  = wr_idx_i - 7'd32;
  assign wr_in   = (wr_idx_i >= 7'd32) && (wr_off < 7'(fsize));
  assign wr_slot = PB'(fstart + PW'(wr_off));

  assign rd_phys_o = (rd_idx_i < 7'd32) ? rd_idx_i : 7'd32 + 7'(rd_slot);
  assign rd_data_o = (rd_idx_i < 7'd32) ? gr[rd_idx_i[4:0]] :
                     rd_in ? sr[rd_slot] : '0;

  assign mpos   = flushing ? fcnt : (need_fill ? spos - PW'(1) : spos);
  assign m_slot = PB'(mpos);

  assign mem_req_valid_o = need_spill | (flushing & (fcnt != top)) | (need_fill & ~fill_wait);
  assign mem_req_we_o    = need_spill | flushing;
  assign mem_req_addr_o  = AW'(mpos);
  assign mem_req_wdata_o = sr[m_slot];
  assign bs_top_o        = AW'(spos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fstart    <= '0;
      fsize     <= '0;
      sp        <= '0;
      spos      <= '0;
      fcnt      <= '0;
      flushing  <= 1'b0;
      fill_wait <= 1'b0;
    end else if (!stall_o) begin
      if (call_i && sp != DPW'(DEPTH)) begin
        fstart <= top;
        fsize  <= asize;
        sp     <= sp + DPW'(1);
      end else if (ret_i && !call_i && sp != '0) begin
        fstart <= stk_start[pop_i];
        fsize  <= stk_size[pop_i];
        sp     <= sp - DPW'(1);
      end else if (flush_i && !call_i && !ret_i) begin
        flushing <= 1'b1;
        fcnt     <= spos;
      end
    end else begin
      if (need_spill && mem_req_ready_i)
        spos <= spos + PW'(1);
      if (flushing) begin
        if (fcnt == top)
          flushing <= 1'b0;
        else if (mem_req_ready_i)
          fcnt <= fcnt + PW'(1);
      end
      if (need_fill) begin
        if (!fill_wait && mem_req_ready_i)
          fill_wait <= 1'b1;
        if (fill_wait && mem_rsp_valid_i) begin
          spos      <= spos - PW'(1);
          fill_wait <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !stall_o && call_i && sp != DPW'(DEPTH)) begin
      stk_start[push_i] <= fstart;
      stk_size[push_i]  <= fsize;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_wait && mem_rsp_valid_i)
      sr[m_slot] <= mem_rsp_data_i;
    else if (wr_en_i && !stall_o) begin
      if (wr_idx_i < 7'd32)
        gr[wr_idx_i[4:0]] <= wr_data_i;
      else if (wr_in)
        sr[wr_slot] <= wr_data_i;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)
      && $stable(mem_req_we_o) && $stable(mem_req_wdata_o)); // R10
  AST_ROOM_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_o |-> (top - spos) <= PW'(PHYS)); // R6
  AST_SPILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && mem_req_ready_i && mem_req_we_o && !flushing
      |=> bs_top_o == $past(bs_top_o) + AW'(1)); // R6
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fill_wait && mem_rsp_valid_i |=> bs_top_o == $past(bs_top_o) - AW'(1)); // R7
  AST_BS_BELOW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    spos <= top); // R7
  AST_FLUSH_KEEPS_BS: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |=> $stable(bs_top_o)); // R9
  AST_REQ_ONLY_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> stall_o); // R11

endmodule

// File: tb/test_stack_frame_mapper.sv
module test_stack_frame_mapper;
  localparam int PHYS = 16, DEPTH = 4, DW = 32, AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic call_i = 0, ret_i = 0, flush_i = 0, wr_en_i = 0;
  logic [6:0] alloc_i = 0, rd_idx_i = 0, wr_idx_i = 0, rd_phys_o;
  logic [DW-1:0] rd_data_o, wr_data_i = 0, mem_req_wdata_o, mem_rsp_data_i;
  logic stall_o, mem_req_valid_o, mem_req_ready_i, mem_req_we_o, mem_rsp_valid_i;
  logic [AW-1:0] mem_req_addr_o, bs_top_o;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  stack_frame_mapper #(.PHYS(PHYS), .DEPTH(DEPTH), .DW(DW), .AW(AW)) i_stack_frame_mapper (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .alloc_i(alloc_i),
    .flush_i(flush_i), .rd_idx_i(rd_idx_i), .rd_phys_o(rd_phys_o), .rd_data_o(rd_data_o),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .stall_o(stall_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_we_o(mem_req_we_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_wdata_o(mem_req_wdata_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i), .bs_top_o(bs_top_o));

  // memory model
  logic [DW-1:0] mem [128];
  logic [7:0] lfsr = 8'hA5;
  logic slow = 1'b0;
  logic rsp_v = 1'b0;
  logic [DW-1:0] rsp_d = '0;
  int wcnt = 0, rcnt = 0;
  logic [AW-1:0] wlog [64];
  logic [AW-1:0] rlog [64];

  assign mem_req_ready_i = slow ? lfsr[0] : 1'b1;
  assign mem_rsp_valid_i = rsp_v;
  assign mem_rsp_data_i  = rsp_d;

  always @(posedge clk) begin
    lfsr  <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rsp_v <= 1'b0;
    if (mem_req_valid_o && mem_req_ready_i) begin
      if (mem_req_we_o) begin
        mem[mem_req_addr_o[6:0]] <= mem_req_wdata_o;
        wlog[wcnt % 64] <= mem_req_addr_o;
        wcnt <= wcnt + 1;
      end else begin
        rsp_d <= mem[mem_req_addr_o[6:0]];
        rsp_v <= 1'b1;
        rlog[rcnt % 64] <= mem_req_addr_o;
        rcnt <= rcnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; call_i = 0; ret_i = 0; flush_i = 0; wr_en_i = 0; slow = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic do_call(input int sz);
    call_i = 1; alloc_i = 7'(sz);
    @(negedge clk);
    call_i = 0;
  endtask

  task automatic do_ret();
    ret_i = 1;
    @(negedge clk);
    ret_i = 0;
  endtask

  task automatic wr(input int idx, input logic [31:0] v);
    wr_en_i = 1; wr_idx_i = 7'(idx); wr_data_i = v;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d, output logic [6:0] p);
    rd_idx_i = 7'(idx);
    #1;
    d = rd_data_o; p = rd_phys_o;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400 && stall_o; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic [6:0] p;
    do_reset();
    check(stall_o == 0, "R12 stall", 32'(stall_o), 0);
    check(mem_req_valid_o == 0, "R12 req", 32'(mem_req_valid_o), 0);
    check(bs_top_o == 0, "R12 bs_top", 32'(bs_top_o), 0);
    rd(32, d, p);
    check(d == 0, "R12 no frame read", d, 0);
  endtask

  task automatic t_translate();
    logic [31:0] d; logic [6:0] p;
    bit ok;
    do_reset();
    wr(5, 32'h55);
    do_call(8);
    rd(33, d, p);
    check(p == 7'd33, "R2 phys of r33 frame0", 32'(p), 33);
    for (int i = 0; i < 8; i++) wr(32 + i, 32'h100 + i);
    do_call(6);
    rd(32, d, p);
    check(p == 7'd40, "R2 phys of r32 frame1", 32'(p), 40);
    rd(37, d, p);
    check(p == 7'd45, "R2 phys of r37 frame1", 32'(p), 45);
    for (int i = 0; i < 6; i++) wr(32 + i, 32'h200 + i);
    rd(5, d, p);
    check(d == 32'h55 && p == 7'd5, "R1 global r5", d, 32'h55);
    rd(38, d, p);
    check(d == 0, "R3 read beyond frame", d, 0);
    do_ret();
    ok = 1;
    for (int i = 0; i < 8; i++) begin
      rd(32 + i, d, p);
      if (d != 32'h100 + i) ok = 0;
    end
    check(ok, "R4 caller values", d, 32'h107);
    rd(32, d, p);
    check(p == 7'd32, "R4 caller start", 32'(p), 32);
    do_call(2);
    wr(34, 32'hBAD);
    do_ret();
    do_call(6);
    rd(34, d, p);
    check(d == 32'h202, "R3 write beyond frame ignored", d, 32'h202);
    rd(5, d, p);
    check(d == 32'h55, "R1 global kept", d, 32'h55);
    check(stall_o == 0, "R6 no stall when fits", 32'(stall_o), 0);
  endtask

  task automatic t_clamp();
    logic [31:0] d; logic [6:0] p;
    do_reset();
    do_call(100);
    check(stall_o == 0, "R3 clamped frame fits", 32'(stall_o), 0);
    wr(47, 32'h77);
    rd(47, d, p);
    check(d == 32'h77 && p == 7'd47, "R3 last slot of clamped frame", d, 32'h77);
    wr(48, 32'h5);
    rd(48, d, p);
    check(d == 0, "R3 clamp boundary", d, 0);
  endtask

  task automatic t_depth();
    logic [31:0] d; logic [6:0] p;
    do_reset();
    do_ret();
    do_call(3);
    rd(32, d, p);
    check(p == 7'd32, "R5 return with no frame ignored", 32'(p), 32);
    do_call(1); do_call(1); do_call(1);
    do_call(2);
    rd(32, d, p);
    check(p == 7'd37, "R5 call at full depth ignored", 32'(p), 37);
    wr(33, 32'h9);
    rd(33, d, p);
    check(d == 0, "R5 frame size kept", d, 0);
    do_ret();
    rd(32, d, p);
    check(p == 7'd36, "R5 stack intact", 32'(p), 36);
  endtask

  task automatic t_spill_fill();
    logic [31:0] d; logic [6:0] p;
    int w0, r0;
    bit ok;
    do_reset();
    slow = 1;
    do_call(12);
    for (int i = 0; i < 12; i++) wr(32 + i, 32'h1000 + i);
    wr(7, 32'h77);
    w0 = wcnt;
    do_call(10);
    check(stall_o == 1, "R6 stall after overflow call", 32'(stall_o), 1);
    wr_en_i = 1; wr_idx_i = 7; wr_data_i = 32'hEE; call_i = 1; alloc_i = 3;
    @(negedge clk);
    wr_en_i = 0; call_i = 0;
    wait_idle();
    check(wcnt - w0 == 6, "R6 spill count", 32'(wcnt - w0), 6);
    ok = 1;
    for (int k = 0; k < 6; k++) if (wlog[(w0 + k) % 64] != AW'(k)) ok = 0;
    check(ok, "R6 spill order", 32'(wlog[w0 % 64]), 0);
    ok = 1;
    for (int k = 0; k < 6; k++) if (mem[k] != 32'h1000 + k) ok = 0;
    check(ok, "R8 spilled words", mem[0], 32'h1000);
    check(bs_top_o == 6, "R6 bs_top after spill", 32'(bs_top_o), 6);
    rd(7, d, p);
    check(d == 32'h77, "R11 write during stall ignored", d, 32'h77);
    rd(32, d, p);
    check(p == 7'd44, "R11 call during stall ignored", 32'(p), 44);
    for (int i = 0; i < 10; i++) wr(32 + i, 32'h2000 + i);
    r0 = rcnt;
    do_ret();
    check(stall_o == 1, "R7 stall after return", 32'(stall_o), 1);
    wait_idle();
    check(rcnt - r0 == 6, "R7 fill count", 32'(rcnt - r0), 6);
    check(rlog[r0 % 64] == 5 && rlog[(r0 + 5) % 64] == 0, "R7 fill order",
          32'(rlog[r0 % 64]), 5);
    check(bs_top_o == 0, "R7 bs_top after fill", 32'(bs_top_o), 0);
    ok = 1;
    for (int i = 0; i < 12; i++) begin
      rd(32 + i, d, p);
      if (d != 32'h1000 + i) ok = 0;
    end
    check(ok, "R7 caller values restored", d, 32'h100b);
    slow = 0;
  endtask

  task automatic t_flush();
    logic [31:0] d; logic [6:0] p;
    int w0;
    bit ok;
    do_reset();
    do_call(12);
    for (int i = 0; i < 12; i++) wr(32 + i, 32'h3000 + i);
    do_call(10);
    wait_idle();
    for (int i = 0; i < 10; i++) wr(32 + i, 32'h4000 + i);
    w0 = wcnt;
    flush_i = 1;
    @(negedge clk);
    flush_i = 0;
    check(stall_o == 1, "R9 stall during flush", 32'(stall_o), 1);
    wait_idle();
    check(wcnt - w0 == 16, "R9 flush count", 32'(wcnt - w0), 16);
    check(wlog[w0 % 64] == 6, "R9 flush starts at bs_top", 32'(wlog[w0 % 64]), 6);
    ok = 1;
    for (int k = 0; k < 6; k++) if (mem[6 + k] != 32'h3006 + k) ok = 0;
    for (int i = 0; i < 10; i++) if (mem[12 + i] != 32'h4000 + i) ok = 0;
    check(ok, "R8 flushed words", mem[12], 32'h4000);
    check(bs_top_o == 6, "R9 bs_top unchanged", 32'(bs_top_o), 6);
    rd(32, d, p);
    check(d == 32'h4000, "R9 registers unchanged", d, 32'h4000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_translate();
    t_clamp();
    t_depth();
    t_spill_fill();
    t_flush();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule